// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a group of general-purpose input pins and turns chosen level or edge conditions on them into one interrupt line. Every pin passes through a two-flop synchronizer. A per-pin cell then decides, from three configuration bits, whether the pin raises status on a level or on an edge. For edges it also decides whether one edge or both edges count, and which polarity applies. Edge status is latched until software clears it. Level status follows the pin. An enable mask selects which raw status bits reach the combined interrupt output.

Software reaches the block over a simple 32-bit register bus. Writes are single-cycle strobes and reads are combinational from the address. The register window holds four configuration registers (sense, dual-edge, polarity and enable), two status views (raw and masked) and a write-one clear register.

Each pin cell is a two-state machine with states ST_IDLE (no pending edge) and ST_PEND (edge latched). The cell has three transitions:
- **arm** (ST_IDLE to ST_PEND): a qualifying edge while the pin is in edge mode.
- **clear** (ST_PEND to ST_IDLE): a write-one clear in a cycle with no qualifying edge.
- **drop** (ST_PEND to ST_IDLE): the pin is switched to level mode.

Top module: `gpioirq_top`

## Requirements
- R1: After reset every register reads 0, raw status is 0 and `irq_o` is 0.
- R2: Register offsets are 0x04 sense, 0x08 dual-edge, 0x0C polarity, 0x10 enable, 0x14 raw status (read only), 0x18 masked status (read only) and 0x1C clear (write only). Configuration registers keep bits [N_PINS-1:0] of a write. Bits above N_PINS read 0, and any other offset reads 0.
- R3: In edge mode (sense bit 0) with dual-edge bit 0, polarity bit 1 latches raw status on a rising edge only, and polarity bit 0 latches it on a falling edge only. The latched bit stays set after the pin returns.
- R4: In edge mode with dual-edge bit 1, both rising and falling edges latch raw status, whatever the polarity bit holds.
- R5: In level mode (sense bit 1), raw status bit n is 1 while the synchronized pin equals polarity bit n. It is not latched, and a clear write has no effect on it.
- R6: Writing 1 to clear bit n resets latched edge status for pin n. Bits written 0 are untouched, and the clear register reads 0.
- R7: An edge on pin n in the same cycle as a clear of bit n leaves raw status bit n set.
- R8: Masked status equals raw status AND enable. `irq_o` is the OR of the masked bits. Raw status does not depend on enable.
- R9: Writes to the raw and masked status offsets change nothing.
- R10: A pin change shows in level-mode raw status after two clock edges, and in edge-mode raw status after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Asynchronous pin inputs |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default of 12 pins and a two-stage synchronizer. This puts the highest pin (bit 11) within reach, along with the unused upper bits 12 to 31, which must read as zero when the enable register is written with all ones. With two synchronizer stages, the level and edge latencies of R10 land on fixed clock edges. That lets the bench land an edge and a clear on the same edge for R7.

// File: rtl/gpioirq_pkg.sv
`timescale 1ns/1ps
package gpioirq_pkg;

    localparam int unsigned BUS_AW = 6;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_SENSE  = 6'h04;
    localparam logic [BUS_AW-1:0] OFF_DUAL   = 6'h08;
    localparam logic [BUS_AW-1:0] OFF_POL    = 6'h0C;
    localparam logic [BUS_AW-1:0] OFF_EN     = 6'h10;
    localparam logic [BUS_AW-1:0] OFF_RAW    = 6'h14;
    localparam logic [BUS_AW-1:0] OFF_MASKED = 6'h18;
    localparam logic [BUS_AW-1:0] OFF_CLR    = 6'h1C;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } cell_state_e;

endpackage

// File: rtl/gpioirq_sync.sv
`timescale 1ns/1ps
module gpioirq_sync #(
    parameter int unsigned WIDTH  = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[LAST];
endmodule

// File: rtl/gpioirq_pin_cell.sv
`timescale 1ns/1ps
module gpioirq_pin_cell
    import gpioirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,     // synchronized pin
    input  logic sense_i,   // 1 level, 0 edge
    input  logic dual_i,    // both edges
    input  logic pol_i,     // 1 rising/high, 0 falling/low
    input  logic clr_i,     // write-one clear strobe
    output logic raw_o
);
    logic        prev_q;
    logic        rise, fall, edge_hit, lvl_hit;
    cell_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    always_comb begin
        rise     = lvl_i & ~prev_q;
        fall     = ~lvl_i & prev_q;
        edge_hit = ~sense_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));
        lvl_hit  = ~(lvl_i ^ pol_i);
    end

    // next state: an edge outranks a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (edge_hit) state_d = ST_PEND;
            ST_PEND: begin
                if (sense_i)                    state_d = ST_IDLE;
                else if (clr_i && !edge_hit)    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (sense_i) raw_o = lvl_hit;
        else         raw_o = (state_q == ST_PEND);
    end
endmodule

// File: rtl/gpioirq_regs.sv
`timescale 1ns/1ps
module gpioirq_regs
    import gpioirq_pkg::*;
#(
    parameter int unsigned N_PINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [BUS_DW-1:0] wdata_i,
    output logic [BUS_DW-1:0] rdata_o,
    input  logic [N_PINS-1:0] raw_i,
    output logic [N_PINS-1:0] sense_o,
    output logic [N_PINS-1:0] dual_o,
    output logic [N_PINS-1:0] pol_o,
    output logic [N_PINS-1:0] en_o,
    output logic [N_PINS-1:0] clr_o
);
    logic [N_PINS-1:0] sense_q, dual_q, pol_q, en_q;
    logic [N_PINS-1:0] wbits, rbits;

    assign wbits = wdata_i[N_PINS-1:0];

    generate
        if (N_PINS < BUS_DW) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wdata_i[BUS_DW-1:N_PINS];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (we_i) begin
            case (addr_i)
                OFF_SENSE: sense_q <= wbits;
                OFF_DUAL:  dual_q  <= wbits;
                OFF_POL:   pol_q   <= wbits;
                OFF_EN:    en_q    <= wbits;
                default: ;
            endcase
        end
    end

    assign clr_o = (we_i && addr_i == OFF_CLR) ? wbits : '0;

    always_comb begin
        case (addr_i)
            OFF_SENSE:  rbits = sense_q;
            OFF_DUAL:   rbits = dual_q;
            OFF_POL:    rbits = pol_q;
            OFF_EN:     rbits = en_q;
            OFF_RAW:    rbits = raw_i;
            OFF_MASKED: rbits = raw_i & en_q;
            default:    rbits = '0;
        endcase
        rdata_o = '0;
        rdata_o[N_PINS-1:0] = rbits;
    end

    assign sense_o = sense_q;
    assign dual_o  = dual_q;
    assign pol_o   = pol_q;
    assign en_o    = en_q;
endmodule

// File: rtl/gpioirq_top.sv
`timescale 1ns/1ps
module gpioirq_top
    import gpioirq_pkg::*;
#(
    parameter int unsigned N_PINS      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq_o
);
    logic [N_PINS-1:0] sync_v, raw_v, sense_q, dual_q, pol_q, en_q, clr_v;

    gpioirq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_v)
    );

    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_cell
            gpioirq_pin_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl_i   (sync_v[p]),
                .sense_i (sense_q[p]),
                .dual_i  (dual_q[p]),
                .pol_i   (pol_q[p]),
                .clr_i   (clr_v[p]),
                .raw_o   (raw_v[p])
            );
        end
    endgenerate

    gpioirq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .raw_i   (raw_v),
        .sense_o (sense_q),
        .dual_o  (dual_q),
        .pol_o   (pol_q),
        .en_o    (en_q),
        .clr_o   (clr_v)
    );

    assign irq_o = |(raw_v & en_q);
endmodule

// File: rtl/gpioirq_chk.sv
`timescale 1ns/1ps
module gpioirq_chk
    import gpioirq_pkg::*;
#(
    parameter int unsigned N_PINS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [N_PINS-1:0] raw_v,
    input logic [N_PINS-1:0] en_q,
    input logic [N_PINS-1:0] sense_q,
    input logic [N_PINS-1:0] pol_q,
    input logic [N_PINS-1:0] sync_v,
    input logic [N_PINS-1:0] clr_v,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_rdata
);
    // R1: clean state right after reset release
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && raw_v == '0));

    // R3: latched edge status holds unless cleared or moved to level mode
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(raw_v) & ~$past(sense_q) & ~$past(clr_v)) & ~sense_q & ~raw_v) == '0));

    // R5: level-mode status tracks the synchronized pin against polarity
    a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_v ^ ~(sync_v ^ pol_q)) & sense_q) == '0);

    // R8: interrupt is the OR of enabled raw bits
    a_r8_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(raw_v & en_q));

    // R6: clear register reads zero
    a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CLR) |-> (bus_rdata == '0));
endmodule

bind gpioirq_top gpioirq_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .raw_v     (raw_v),
    .en_q      (en_q),
    .sense_q   (sense_q),
    .pol_q     (pol_q),
    .sync_v    (sync_v),
    .clr_v     (clr_v),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/gpioirq_top_test.sv
`timescale 1ns/1ps
module gpioirq_top_test;
    import gpioirq_pkg::*;

    localparam int N = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      pins;
    logic              we;
    logic [BUS_AW-1:0] addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic              irq;

    always #5 clk = ~clk;

    gpioirq_top #(.N_PINS(N), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() > 0);
            #1;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // driver tasks
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [BUS_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic expect_reg(input logic [BUS_AW-1:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic expect_irq(input logic e, input string t);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
        wait_cyc(4);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(OFF_SENSE,  32'h0, "R1 sense");
        expect_reg(OFF_DUAL,   32'h0, "R1 dual");
        expect_reg(OFF_POL,    32'h0, "R1 pol");
        expect_reg(OFF_EN,     32'h0, "R1 enable");
        expect_reg(OFF_RAW,    32'h0, "R1 raw");
        expect_reg(OFF_MASKED, 32'h0, "R1 masked");
        expect_irq(1'b0, "R1 irq");

        // R2 map and widths
        wr(OFF_SENSE, 32'h0000_0ABC);
        expect_reg(OFF_SENSE, 32'h0000_0ABC, "R2 sense readback");
        wr(OFF_EN, 32'hFFFF_FFFF);
        expect_reg(OFF_EN, 32'h0000_0FFF, "R2 upper bits zero");
        expect_reg(6'h00, 32'h0, "R2 unmapped offset");
        wr(OFF_EN, 32'h0);
        wr(OFF_SENSE, 32'h0);
        expect_reg(OFF_RAW, 32'h0, "R2 raw idle");

        // R3 / R10 single edge
        wr(OFF_POL, 32'h1);
        set_pins(12'h001);
        wait_cyc(1);
        expect_reg(OFF_RAW, 32'h0, "R10 edge not before third edge");
        expect_reg(OFF_RAW, 32'h1, "R10 edge at third edge");
        set_pins(12'h000);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h1, "R3 latched after fall");
        wr(OFF_CLR, 32'h1);
        expect_reg(OFF_RAW, 32'h0, "R6 clear pin0");
        set_pins(12'h002);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h0, "R3 rise ignored falling polarity");
        set_pins(12'h000);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h2, "R3 falling edge latched");

        // R8 masking
        expect_reg(OFF_MASKED, 32'h0, "R8 masked disabled");
        expect_irq(1'b0, "R8 irq disabled");
        wr(OFF_EN, 32'h2);
        expect_reg(OFF_MASKED, 32'h2, "R8 masked enabled");
        expect_irq(1'b1, "R8 irq enabled");
        wr(OFF_EN, 32'hFFD);
        expect_reg(OFF_MASKED, 32'h0, "R8 masked other bits");
        expect_irq(1'b0, "R8 irq other bits");
        expect_reg(OFF_RAW, 32'h2, "R8 raw ignores enable");
        wr(OFF_CLR, 32'h2);
        wr(OFF_EN, 32'hFFF);
        expect_irq(1'b0, "R8 irq after clear");
        wr(OFF_EN, 32'h0);

        // R6 selective clear
        wr(OFF_DUAL, 32'h00C);
        set_pins(12'h00C);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h00C, "R4 dual rise pins 2,3");
        wr(OFF_CLR, 32'h4);
        expect_reg(OFF_RAW, 32'h008, "R6 only written bit cleared");
        expect_reg(OFF_CLR, 32'h0, "R6 clear reads zero");

        // R4 falling edge in dual mode
        wr(OFF_CLR, 32'h8);
        expect_reg(OFF_RAW, 32'h0, "R6 clear pin3");
        set_pins(12'h004);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h008, "R4 dual fall pin3");
        wr(OFF_CLR, 32'h8);

        // R7 edge wins over clear
        set_pins(12'h000);
        wait_cyc(1);
        wr(OFF_CLR, 32'h4);
        expect_reg(OFF_RAW, 32'h004, "R7 edge beats clear");
        wr(OFF_CLR, 32'h4);
        expect_reg(OFF_RAW, 32'h0, "R7 later clear");

        // R5 / R10 level mode
        wr(OFF_POL, 32'h020);
        wr(OFF_SENSE, 32'h020);
        expect_reg(OFF_RAW, 32'h0, "R5 high level inactive");
        set_pins(12'h020);
        expect_reg(OFF_RAW, 32'h0, "R10 level not after one edge");
        expect_reg(OFF_RAW, 32'h020, "R10 level after two edges");
        wr(OFF_CLR, 32'h020);
        expect_reg(OFF_RAW, 32'h020, "R5 clear no effect");
        set_pins(12'h000);
        wait_cyc(2);
        expect_reg(OFF_RAW, 32'h0, "R5 not latched");
        wr(OFF_POL, 32'h0);
        expect_reg(OFF_RAW, 32'h020, "R5 low level active");
        wr(OFF_SENSE, 32'h0);
        expect_reg(OFF_RAW, 32'h0, "R5 back to edge mode");

        // R9 status offsets are read only; top pin
        wr(OFF_DUAL, 32'h800);
        set_pins(12'h800);
        wait_cyc(3);
        expect_reg(OFF_RAW, 32'h800, "R4 top pin dual rise");
        wr(OFF_RAW, 32'hFFFF_FFFF);
        wr(OFF_MASKED, 32'hFFFF_FFFF);
        expect_reg(OFF_RAW, 32'h800, "R9 raw write ignored");
        expect_reg(OFF_MASKED, 32'h0, "R9 masked write ignored");
        expect_reg(OFF_EN, 32'h0, "R9 enable untouched");
        wr(OFF_EN, 32'h800);
        expect_reg(OFF_MASKED, 32'h800, "R8 top pin masked");
        expect_irq(1'b1, "R8 top pin irq");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule